// File: doc/BRIEF.md
# Instruction-driven waveform sequencer

This block plays back a single-bit waveform described by a short program held in a local instruction store. A program is a list of words, each either a timed level step (drive the line high or low for a given number of clock cycles) or a loop marker (open a counted loop, close the innermost loop). Loops may be nested, and the sequencer walks the program from the first word, counting durations and looping until it meets a stop word or runs off the end of the store.

Software or an offline tool compiles the desired waveform into instruction words. Those words are loaded through a simple write port while the sequencer is idle, and playback starts with a one-cycle strobe. While the program runs, `busy` is high. When it ends, `busy` falls, `done` rises and the line keeps the last level it was driven to. A new strobe replays the stored program.

Top module: `wseq_top`

## Requirements
- R1: After reset, `wave`, `busy` and `done` are all 0.
- R2: A `start` pulse seen while `busy` is 0 raises `busy` and clears `done` at the same edge, and execution begins at address 0. The output keeps its level during that first cycle. A `start` pulse seen while `busy` is 1 has no effect.
- R3: An instruction word has its opcode in bits [17:16] and its count N in bits [15:0]. Opcode 00 drives `wave` to 1 and opcode 01 drives it to 0. For N ≥ 1 the level appears from the edge that executes the instruction, holds for exactly N cycles, and the instruction occupies exactly N cycles.
- R4: A low instruction (opcode 01) with N = 0 takes one cycle and leaves `wave` unchanged.
- R5: A loop-open instruction (opcode 10) with count N makes the enclosed instructions run N times in total. N = 0 behaves as N = 1. The instruction itself takes one cycle and leaves `wave` unchanged.
- R6: A loop-close instruction (opcode 11) takes one cycle and leaves `wave` unchanged. If iterations remain, it returns to the word after the matching loop-open; otherwise execution continues after it. When no loop is open it does nothing but advance.
- R7: Loops nest correctly up to 4 levels deep.
- R8: Playback ends on an all-zero word, or after the instruction at the last address (63) completes. At that edge `busy` falls and `done` rises. `busy` and `done` are never both 1. While idle, `wave` keeps its last level and `done` stays 1 until the next accepted `start`.
- R9: Program words are stored through `wr_en`/`wr_addr`/`wr_data` only while `busy` is 0. A write presented while `busy` is 1 is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle playback request |
| wr_en | input | 1 | Program store write enable |
| wr_addr | input | 6 | Program store write address |
| wr_data | input | 18 | Instruction word (opcode [17:16], count [15:0]) |
| wave | output | 1 | Waveform output (registered) |
| busy | output | 1 | High while a program is executing |
| done | output | 1 | High after playback has ended, until the next start |

## Verification
The hardest situations to reach are a loop-close that meets a completely full loop stack, and a program that plays through every address without a stop word. Both need long, carefully built programs loaded before playback. The stimulus loads a four-level nest whose inner counts include zero and one, and a 64-word program with no zero word. It also injects a `start` and a program write into the middle of a run: the resulting waveform shows whether either one leaked in. A behavioural interpreter of the program predicts every cycle of `wave`, `busy` and `done`.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef enum logic [1:0] {
    OP_HIGH = 2'd0,
    OP_LOW  = 2'd1,
    OP_LOOP = 2'd2,
    OP_NEXT = 2'd3
  } op_e;
endpackage

// File: rtl/wseq_progmem.sv
// Simple dual-port program store: one write port, one synchronous read port.
module wseq_progmem #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 2 ** AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wseq_decode.sv
// Splits an instruction word into its fields and classifies it.
module wseq_decode
  import wseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W+1:0] word,
  output op_e              op,
  output logic [CNT_W-1:0] cnt,
  output logic             is_term,
  output logic             is_level,
  output logic             level,
  output logic [CNT_W-1:0] loop_extra
);
  always_comb begin
    op         = op_e'(word[CNT_W+1:CNT_W]);
    cnt        = word[CNT_W-1:0];
    is_term    = (word == '0);
    is_level   = (op == OP_HIGH) || (op == OP_LOW);
    level      = (op == OP_HIGH);
    loop_extra = (cnt == '0) ? '0 : cnt - 1'b1;
  end
endmodule

// File: rtl/wseq_loopstack.sv
// Stack of loop frames: return address and remaining extra iterations.
module wseq_loopstack #(
  parameter int DEPTH = 4,
  parameter int AW    = 6,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          dec,
  input  logic [AW-1:0] push_ret,
  input  logic [CW-1:0] push_rem,
  output logic [AW-1:0] top_ret,
  output logic [CW-1:0] top_rem,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] TOPV = PW'(DEPTH);

  logic [PW-1:0] lvl;
  logic [AW-1:0] ret_r [DEPTH];
  logic [CW-1:0] rem_r [DEPTH];

  assign empty = (lvl == '0);
  assign full  = (lvl == TOPV);

  always_ff @(posedge clk) begin
    if (rst || clear) lvl <= '0;
    else if (push && !full) lvl <= lvl + 1'b1;
    else if (pop && !empty) lvl <= lvl - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PW-1:0] SLOT  = PW'(g);
    localparam logic [PW-1:0] SLOT1 = PW'(g + 1);
    always_ff @(posedge clk) begin
      if (!(rst || clear)) begin
        if (push && !full && lvl == SLOT) begin
          ret_r[g] <= push_ret;
          rem_r[g] <= push_rem;
        end else if (dec && lvl == SLOT1) begin
          rem_r[g] <= rem_r[g] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    top_ret = '0;
    top_rem = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lvl == PW'(i + 1)) begin
        top_ret = ret_r[i];
        top_rem = rem_r[i];
      end
    end
  end

  // R7: the frame count never exceeds the configured nesting depth
  p_depth_r7: assert property (@(posedge clk) disable iff (rst)
    lvl <= TOPV);
  // R6: the controller pops or decrements only an existing frame
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    (pop || dec) |-> !empty);
  // R6: a decrement never touches a frame whose count is already zero
  p_dec_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    dec |-> (top_rem != '0));
endmodule

// File: rtl/wseq_top.sv
// Instruction-driven waveform sequencer.
module wseq_top
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int NEST   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W+1:0]  wr_data,
  output logic              wave,
  output logic              busy,
  output logic              done
);
  localparam int DW = CNT_W + 2;
  localparam logic [ADDR_W-1:0] LAST = '1;
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic              busy_q, done_q, wave_q;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0]  hold_q, hold_d, cur;
  logic              wave_d;
  logic [DW-1:0]     instr;

  op_e               op;
  logic [CNT_W-1:0]  cnt, loop_extra;
  logic              is_term, is_level, level;

  logic              push, pop, dec, adv, finish, launch;
  logic [ADDR_W-1:0] top_ret;
  logic [CNT_W-1:0]  top_rem;
  logic              st_empty, st_full;

  assign launch = start && !busy_q;

  wseq_progmem #(.AW(ADDR_W), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (wr_en && !busy_q),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (pc_d),
    .rdata (instr)
  );

  wseq_decode #(.CNT_W(CNT_W)) u_dec (
    .word       (instr),
    .op         (op),
    .cnt        (cnt),
    .is_term    (is_term),
    .is_level   (is_level),
    .level      (level),
    .loop_extra (loop_extra)
  );

  wseq_loopstack #(.DEPTH(NEST), .AW(ADDR_W), .CW(CNT_W)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .clear    (launch),
    .push     (push),
    .pop      (pop),
    .dec      (dec),
    .push_ret (pc_q + 1'b1),
    .push_rem (loop_extra),
    .top_ret  (top_ret),
    .top_rem  (top_rem),
    .empty    (st_empty),
    .full     (st_full)
  );

  assign cur = (hold_q == '0) ? cnt : hold_q;

  always_comb begin
    pc_d   = pc_q;
    hold_d = hold_q;
    wave_d = wave_q;
    push   = 1'b0;
    pop    = 1'b0;
    dec    = 1'b0;
    adv    = 1'b0;
    finish = 1'b0;
    if (!busy_q) begin
      if (start) begin
        pc_d   = '0;
        hold_d = '0;
      end
    end else if (is_term) begin
      finish = 1'b1;
    end else begin
      unique case (op)
        OP_HIGH, OP_LOW: begin
          if (cnt == '0) begin
            adv = 1'b1;
          end else begin
            wave_d = level;
            if (cur == ONE) begin
              adv    = 1'b1;
              hold_d = '0;
            end else begin
              hold_d = cur - 1'b1;
            end
          end
        end
        OP_LOOP: begin
          push = !st_full;
          adv  = 1'b1;
        end
        OP_NEXT: begin
          if (st_empty) begin
            adv = 1'b1;
          end else if (top_rem == '0) begin
            pop = 1'b1;
            adv = 1'b1;
          end else begin
            dec  = 1'b1;
            pc_d = top_ret;
          end
        end
        default: adv = 1'b1;
      endcase
      if (adv) begin
        if (pc_q == LAST) finish = 1'b1;
        else              pc_d   = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wave_q <= 1'b0;
      pc_q   <= '0;
      hold_q <= '0;
    end else begin
      pc_q   <= pc_d;
      hold_q <= hold_d;
      wave_q <= wave_d;
      if (launch) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (busy_q && finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign wave = wave_q;
  assign busy = busy_q;
  assign done = done_q;

  // R8: busy and done never overlap
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));
  // R2: an idle start raises busy and clears done at the next edge
  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> (busy_q && !done_q));
  // R8: while idle the waveform does not move
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(wave_q));
  // R3: an executing level step with a non-zero count drives its level
  p_level_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && is_level && cnt != '0) |=> (wave_q == $past(level)));
  // R5 / R6: loop markers leave the output alone
  p_marker_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !is_term && !is_level) |=> $stable(wave_q));
  // R4: a zero-length low step leaves the output alone
  p_zero_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op == OP_LOW && cnt == '0) |=> $stable(wave_q));
endmodule

// File: tb/sim_wseq_top.sv
`timescale 1ns/1ps
module sim_wseq_top;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int DW = CW + 2;
  localparam int SIZE = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wave, busy, done;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  logic [DW-1:0] prog [SIZE];
  bit exp_q [$];
  bit last_wave = 0;
  bit inj_en = 0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_data = '0;

  always #2.5 clk = ~clk;

  wseq_top #(.ADDR_W(AW), .CNT_W(CW), .NEST(4)) u0 (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .wave(wave), .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] mk(input int op, input int n);
    return {op[1:0], n[CW-1:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < SIZE; i++) prog[i] = '0;
  endtask

  task automatic load_all();
    for (int i = 0; i < SIZE; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = prog[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Behavioural interpreter: one queue entry per executed clock cycle.
  task automatic model();
    int pc = 0;
    int rs [$];
    int rr [$];
    bit o = last_wave;
    exp_q.delete();
    forever begin
      int w, op, n;
      bit adv = 0;
      w  = int'(prog[pc]);
      op = w >> 16;
      n  = w & 'hFFFF;
      if (w == 0) begin exp_q.push_back(o); break; end
      if (op <= 1) begin
        if (n == 0) exp_q.push_back(o);
        else begin
          o = (op == 0);
          for (int j = 0; j < n; j++) exp_q.push_back(o);
        end
        adv = 1;
      end else if (op == 2) begin
        if (rs.size() < 4) begin
          rs.push_back(pc + 1);
          rr.push_back(n == 0 ? 0 : n - 1);
        end
        exp_q.push_back(o);
        adv = 1;
      end else begin
        exp_q.push_back(o);
        if (rs.size() == 0) adv = 1;
        else if (rr[rr.size()-1] == 0) begin
          void'(rs.pop_back()); void'(rr.pop_back()); adv = 1;
        end else begin
          rr[rr.size()-1] = rr[rr.size()-1] - 1;
          pc = rs[rs.size()-1];
        end
      end
      if (adv) begin
        if (pc == SIZE - 1) break;
        pc++;
      end
      if (exp_q.size() > 20000) break;
    end
  endtask

  task automatic run(input string req);
    int m;
    model();
    m = exp_q.size();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R2 busy after start"}, busy, 1);
    chk({req, " R2 done cleared"}, done, 0);
    chk({req, " R2 level kept at start"}, wave, last_wave);
    for (int k = 0; k < m; k++) begin
      if (inj_en && k == 1) begin
        start = 1'b1; wr_en = 1'b1; wr_addr = inj_addr; wr_data = inj_data;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      chk({req, " wave"}, wave, exp_q[k]);
      chk({req, " R8 busy"}, busy, (k < m - 1) ? 1 : 0);
      chk({req, " R8 done"}, done, (k == m - 1) ? 1 : 0);
    end
    last_wave = exp_q[m-1];
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({req, " R8 idle level held"}, wave, last_wave);
      chk({req, " R8 done held"}, done, 1);
      chk({req, " R8 idle not busy"}, busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wave", wave, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);

    // R3: plain level steps
    clear_prog();
    prog[0] = mk(0, 3); prog[1] = mk(1, 2); prog[2] = mk(0, 1);
    prog[3] = mk(1, 4); prog[4] = mk(0, 2);
    load_all();
    run("R3 levels");

    // R5 R6: single loop
    clear_prog();
    prog[0] = mk(1, 1); prog[1] = mk(2, 3); prog[2] = mk(0, 2);
    prog[3] = mk(1, 1); prog[4] = mk(3, 0); prog[5] = mk(0, 1);
    load_all();
    run("R5 R6 loop");

    // R7 R4 R5 R6: four-level nest, zero counts, stray close
    clear_prog();
    prog[0]  = mk(2, 2);  prog[1]  = mk(2, 0);  prog[2]  = mk(0, 1);
    prog[3]  = mk(2, 3);  prog[4]  = mk(1, 1);  prog[5]  = mk(2, 2);
    prog[6]  = mk(0, 1);  prog[7]  = mk(1, 0);  prog[8]  = mk(3, 0);
    prog[9]  = mk(3, 0);  prog[10] = mk(3, 0);  prog[11] = mk(3, 0);
    prog[12] = mk(3, 0);  prog[13] = mk(1, 2);  prog[14] = mk(1, 0);
    prog[15] = mk(0, 3);
    load_all();
    run("R7 R4 R6 nest");

    // R8: no stop word, runs to the last address
    for (int i = 0; i < SIZE; i++)
      prog[i] = (i % 2 == 0) ? mk(0, 1 + (i % 3)) : mk(1, 1);
    prog[SIZE-1] = mk(0, 2);
    load_all();
    run("R8 end of store");

    // R9 R2: write and start during playback are discarded
    clear_prog();
    prog[0] = mk(0, 2); prog[1] = mk(1, 3); prog[2] = mk(0, 4);
    prog[3] = mk(1, 2); prog[4] = mk(2, 2); prog[5] = mk(0, 1);
    prog[6] = mk(3, 0);
    load_all();
    inj_en = 1; inj_addr = AW'(2); inj_data = mk(1, 9);
    run("R9 R2 busy write");
    inj_en = 0;
    run("R9 replay unchanged");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule